// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable, small-depth model of a synchronous burst SRAM whose shared data bus can carry a read, then a write, then a read on consecutive clocks with no idle cycle between them. Every command input is sampled on the rising clock edge: the word address, the write flag, the per-byte write enables, three chip selects, the burst advance flag and the burst order. Write data does not travel with its address. It arrives on a later edge, so the bus direction never has to turn around. A static mode input chooses between two read timings. In flow-through mode, read data appears right after the edge that carries the address. In pipelined mode, it appears one edge later, from an output register.

Writes still waiting for their data are held in a short slot pipeline. In pipelined mode, a read whose output register loads on the same edge as a matching write's data returns the merged new bytes. A two-bit burst counter steps through four beats, in either wrapping-increment order or XOR order. Output enable and a doze input act on the output drive at once, without waiting for a clock. The data bus is modelled as a data vector plus a drive flag that marks the high-impedance state.

The control state machine has four states: `S_IDLE`, `S_RD`, `S_WR` and `S_SLEEP`. Its transitions are as follows. Doze high moves any state to `S_SLEEP`. A load with a full chip select moves any state to `S_RD` or `S_WR`, chosen by `wr`. An advance in `S_RD` or `S_WR` stays in that state and steps the burst. An advance in `S_IDLE` or `S_SLEEP` goes to `S_IDLE`. A load without a full chip select goes to `S_IDLE`. Reset enters `S_IDLE`.

Top module: `zbt_sram`

## Requirements
- R1: During reset and right after it, `rd_drive` is 0 and `rd_data` is zero.
- R2: A load (`burst_adv`=0) starts an operation only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0 all hold. Any other pattern is a deselect: nothing is written and no read data is driven.
- R3: A read whose address is sampled at edge k drives `rd_drive`=1 with the stored word after edge k in flow-through mode (`flow_mode`=1), and after edge k+1 in pipelined mode (`flow_mode`=0).
- R4: Write data on `din` is taken at edge k+1 for a write addressed at edge k in flow-through mode, and at edge k+2 in pipelined mode. No data is driven during a write.
- R5: `ben[0]` enables bits 8:0 and `ben[1]` enables bits 17:9. Disabled bytes keep their old contents.
- R6: Reads and writes may alternate on every clock. In pipelined mode, a read addressed one edge after a write to the same word returns that write's new bytes, merged byte by byte with the stored word.
- R7: With `order_xor`=0, beat n of a burst uses low address bits (start + n) mod 4, and the upper address bits do not change.
- R8: With `order_xor`=1, beat n uses low address bits start XOR n, and the upper address bits do not change.
- R9: `out_en`=0 forces `rd_drive`=0 and `rd_data` to zero at once, without waiting for a clock edge.
- R10: `doze`=1 forces `rd_drive`=0 at once. Commands sampled while it is high are dropped, and the stored contents are kept.
- R11: An advance (`burst_adv`=1) sampled when no read or write burst is active is a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands sampled on its rising edge |
| rst_n | input | 1 | Active-low reset of control state |
| addr | input | AW | Word address for a load |
| din | input | NB*BW | Write data, taken on the late data edge |
| wr | input | 1 | 1 = write, 0 = read (load cycles only) |
| ben | input | NB | Per-byte write enables, sampled with the address |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| burst_adv | input | 1 | 1 = advance current burst, 0 = load new command |
| order_xor | input | 1 | Static burst order: 0 wrapping increment, 1 XOR |
| flow_mode | input | 1 | Static read timing: 1 flow-through, 0 pipelined |
| out_en | input | 1 | Asynchronous output enable |
| doze | input | 1 | Asynchronous power-down request |
| rd_data | output | NB*BW | Read data, zero when not driven |
| rd_drive | output | 1 | 1 when the data bus is driven, 0 for high impedance |

## Verification
The bench mixes seeded random traffic with directed cases. The random traffic is concentrated on eight addresses, so that a read and a write to the same word often fall on neighbouring edges. If the pipelined forwarding path were missing, such a read would return the stale stored word. If the late-write distance were wrong, a write would commit the bus value of the wrong cycle. Directed bursts starting in the middle of an aligned group of four expose a counter that wraps into the upper address bits or uses the wrong order. Partial byte writes catch a merge that overwrites the disabled byte. Writes with one chip select wrong, and writes issued while dozing, must leave the word unchanged; a design that ignored either condition would corrupt memory. An advance after a deselect must stay silent, and toggling output enable in mid-read must cut the drive at once.

// File: rtl/zsr_pkg.sv
package zsr_pkg;

    // Operation accepted on the most recent clock edge.
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_RD    = 2'd1,
        S_WR    = 2'd2,
        S_SLEEP = 2'd3
    } op_e;

    // Low address bits of one burst beat.
    function automatic logic [1:0] burst_low(
        input logic [1:0] start,
        input logic [1:0] beat,
        input logic       xor_order
    );
        logic [1:0] lin;
        lin = start + beat;
        return xor_order ? (start ^ beat) : lin;
    endfunction

endpackage

// File: rtl/zsr_ctl.sv
module zsr_ctl
    import zsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic doze,
    input  logic chip_sel,
    input  logic burst_adv,
    input  logic wr,
    output op_e  op_st,
    output op_e  op_nxt,
    output logic load_cmd,
    output logic step_cmd
);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_st <= S_IDLE;
        end else begin
            op_st <= op_nxt;
        end
    end

    // Next-state selection
    always_comb begin
        op_nxt = S_IDLE;
        unique case (op_st)
            S_IDLE, S_SLEEP: begin
                if (doze) begin
                    op_nxt = S_SLEEP;
                end else if (!burst_adv && chip_sel) begin
                    op_nxt = wr ? S_WR : S_RD;
                end else begin
                    op_nxt = S_IDLE;
                end
            end
            S_RD, S_WR: begin
                if (doze) begin
                    op_nxt = S_SLEEP;
                end else if (burst_adv) begin
                    op_nxt = op_st;
                end else if (chip_sel) begin
                    op_nxt = wr ? S_WR : S_RD;
                end else begin
                    op_nxt = S_IDLE;
                end
            end
        endcase
    end

    // Command outputs to the burst counter
    always_comb begin
        load_cmd = !doze && !burst_adv && chip_sel;
        step_cmd = !doze && burst_adv && ((op_st == S_RD) || (op_st == S_WR));
    end

endmodule

// File: rtl/zsr_burst.sv
module zsr_burst
    import zsr_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_cmd,
    input  logic          step_cmd,
    input  logic          order_xor,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] op_addr
);

    localparam int CW = 2;

    logic [AW-1:0] base_q;
    logic [CW-1:0] beat_q;
    logic [CW-1:0] beat_n;

    always_comb begin
        beat_n  = beat_q + 2'd1;
        op_addr = load_cmd ? addr_in
                           : {base_q[AW-1:CW], burst_low(base_q[CW-1:0], beat_n, order_xor)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (load_cmd) begin
            base_q <= addr_in;
            beat_q <= '0;
        end else if (step_cmd) begin
            beat_q <= beat_n;
        end
    end

endmodule

// File: rtl/zsr_wpipe.sv
module zsr_wpipe #(
    parameter int AW = 6,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flow_mode,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [NB-1:0] push_ben,
    output logic          due_v,
    output logic [AW-1:0] due_addr,
    output logic [NB-1:0] due_ben
);

    localparam int STAGES = 2;
    localparam int FLOW_TAP = 0;
    localparam int PIPE_TAP = STAGES - 1;

    logic          slot_v [STAGES];
    logic [AW-1:0] slot_a [STAGES];
    logic [NB-1:0] slot_b [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                slot_v[s] <= 1'b0;
                slot_a[s] <= '0;
                slot_b[s] <= '0;
            end
        end else begin
            slot_v[0] <= push;
            slot_a[0] <= push_addr;
            slot_b[0] <= push_ben;
            for (int s = 1; s < STAGES; s++) begin
                slot_v[s] <= slot_v[s-1];
                slot_a[s] <= slot_a[s-1];
                slot_b[s] <= slot_b[s-1];
            end
        end
    end

    always_comb begin
        due_v    = flow_mode ? slot_v[FLOW_TAP] : slot_v[PIPE_TAP];
        due_addr = flow_mode ? slot_a[FLOW_TAP] : slot_a[PIPE_TAP];
        due_ben  = flow_mode ? slot_b[FLOW_TAP] : slot_b[PIPE_TAP];
    end

endmodule

// File: rtl/zsr_array.sv
module zsr_array #(
    parameter int AW = 6,
    parameter int BW = 9,
    parameter int NB = 2
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [NB*BW-1:0] wdata,
    input  logic [NB-1:0]    wben,
    input  logic [AW-1:0]    raddr,
    output logic [NB*BW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;
    localparam int DW    = NB * BW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < NB; b++) begin
                if (wben[b]) begin
                    mem[waddr][b*BW +: BW] <= wdata[b*BW +: BW];
                end
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zsr_pkg::*;
#(
    parameter int AW = 6,
    parameter int BW = 9,
    parameter int NB = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic [NB*BW-1:0] din,
    input  logic             wr,
    input  logic [NB-1:0]    ben,
    input  logic             cs0_n,
    input  logic             cs1,
    input  logic             cs2_n,
    input  logic             burst_adv,
    input  logic             order_xor,
    input  logic             flow_mode,
    input  logic             out_en,
    input  logic             doze,
    output logic [NB*BW-1:0] rd_data,
    output logic             rd_drive
);

    localparam int DW = NB * BW;

    logic          chip_sel;
    op_e           op_st;
    op_e           op_nxt;
    logic          load_cmd;
    logic          step_cmd;
    logic [AW-1:0] op_addr;
    logic [AW-1:0] rd_addr_q;
    logic          due_v;
    logic [AW-1:0] due_addr;
    logic [NB-1:0] due_ben;
    logic [DW-1:0] arr_q;
    logic [DW-1:0] fwd_word;
    logic          pipe_v_q;
    logic [DW-1:0] pipe_d_q;
    logic          out_valid;
    logic [DW-1:0] out_word;

    assign chip_sel = !cs0_n && cs1 && !cs2_n;

    zsr_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .doze      (doze),
        .chip_sel  (chip_sel),
        .burst_adv (burst_adv),
        .wr        (wr),
        .op_st     (op_st),
        .op_nxt    (op_nxt),
        .load_cmd  (load_cmd),
        .step_cmd  (step_cmd)
    );

    zsr_burst #(.AW(AW)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_cmd  (load_cmd),
        .step_cmd  (step_cmd),
        .order_xor (order_xor),
        .addr_in   (addr),
        .op_addr   (op_addr)
    );

    zsr_wpipe #(.AW(AW), .NB(NB)) u_wpipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .flow_mode (flow_mode),
        .push      (op_nxt == S_WR),
        .push_addr (op_addr),
        .push_ben  (ben),
        .due_v     (due_v),
        .due_addr  (due_addr),
        .due_ben   (due_ben)
    );

    zsr_array #(.AW(AW), .BW(BW), .NB(NB)) u_array (
        .clk   (clk),
        .we    (due_v),
        .waddr (due_addr),
        .wdata (din),
        .wben  (due_ben),
        .raddr (rd_addr_q),
        .rdata (arr_q)
    );

    // Address of the operation accepted on the last edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_addr_q <= '0;
        end else begin
            rd_addr_q <= op_addr;
        end
    end

    // Byte-wise merge of the write whose data lands on this edge
    for (genvar b = 0; b < NB; b++) begin : g_fwd
        assign fwd_word[b*BW +: BW] =
            (due_v && (due_addr == rd_addr_q) && due_ben[b]) ? din[b*BW +: BW]
                                                             : arr_q[b*BW +: BW];
    end

    // Pipelined output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_v_q <= 1'b0;
            pipe_d_q <= '0;
        end else begin
            pipe_v_q <= (op_st == S_RD);
            pipe_d_q <= fwd_word;
        end
    end

    // Output drive, asynchronous gating by out_en and doze
    always_comb begin
        out_valid = flow_mode ? (op_st == S_RD) : pipe_v_q;
        out_word  = flow_mode ? arr_q : pipe_d_q;
        rd_drive  = out_en && !doze && out_valid;
        rd_data   = rd_drive ? out_word : '0;
    end

endmodule

// File: rtl/zsr_chk.sv
module zsr_chk
    import zsr_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic flow_mode,
    input logic out_en,
    input logic doze,
    input logic burst_adv,
    input logic chip_sel,
    input op_e  op_st,
    input logic rd_drive
);

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_mode && !doze && !burst_adv && !chip_sel) |=> !rd_drive); // R2

    AST_FLOW_RD_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_mode && op_st == S_RD && out_en && !doze) |-> rd_drive); // R3

    AST_PIPE_RD_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_mode && op_st == S_RD) |=> (rd_drive || !out_en || doze || flow_mode)); // R3

    AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_mode && op_st == S_WR) |-> !rd_drive); // R4

    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !rd_drive); // R9

    AST_DOZE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        doze |-> !rd_drive); // R10

    AST_ADV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_st == S_IDLE && burst_adv && !doze) |=> (op_st == S_IDLE)); // R11

endmodule

bind zbt_sram zsr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flow_mode (flow_mode),
    .out_en    (out_en),
    .doze      (doze),
    .burst_adv (burst_adv),
    .chip_sel  (chip_sel),
    .op_st     (op_st),
    .rd_drive  (rd_drive)
);

// File: tb/zbt_sram_bench.sv
`timescale 1ns/1ps
module zbt_sram_bench;

    localparam int AW = 6;
    localparam int BW = 9;
    localparam int NB = 2;
    localparam int DW = NB * BW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          wr = 1'b0;
    logic [NB-1:0] ben = '0;
    logic          cs0_n = 1'b1;
    logic          cs1 = 1'b0;
    logic          cs2_n = 1'b1;
    logic          burst_adv = 1'b0;
    logic          order_xor = 1'b0;
    logic          flow_mode = 1'b1;
    logic          out_en = 1'b1;
    logic          doze = 1'b0;
    logic [DW-1:0] rd_data;
    logic          rd_drive;

    int n_tests = 0;
    int n_fail = 0;
    string cur_req = "R1";

    // Reference model state
    logic [DW-1:0] refmem [DEPTH];
    int            m_st = 0;
    logic [AW-1:0] m_base = '0;
    logic [AW-1:0] m_ra = '0;
    logic [1:0]    m_cnt = '0;
    logic          s1v = 1'b0, s2v = 1'b0;
    logic [AW-1:0] s1a = '0, s2a = '0;
    logic [NB-1:0] s1b = '0, s2b = '0;
    logic          epv = 1'b0;
    logic [DW-1:0] epd = '0;
    logic          e_en = 1'b0;
    logic [DW-1:0] e_d = '0;

    zbt_sram #(.AW(AW), .BW(BW), .NB(NB)) u_zbt_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .wr(wr), .ben(ben),
        .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .burst_adv(burst_adv),
        .order_xor(order_xor), .flow_mode(flow_mode), .out_en(out_en),
        .doze(doze), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    always #2.5 clk = ~clk;

    function automatic logic [1:0] beat_low(input logic [1:0] s, input logic [1:0] n, input logic x);
        logic [1:0] inc;
        inc = s + n;
        return x ? (s ^ n) : inc;
    endfunction

    function automatic logic [DW-1:0] merge_bytes(input logic [DW-1:0] old_w,
                                                  input logic [DW-1:0] new_w,
                                                  input logic [NB-1:0] mask);
        logic [DW-1:0] r;
        r = old_w;
        for (int b = 0; b < NB; b++) begin
            if (mask[b]) r[b*BW +: BW] = new_w[b*BW +: BW];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic got_en, input logic [DW-1:0] got_d,
                       input logic exp_en, input logic [DW-1:0] exp_d);
        n_tests++;
        if (got_en !== exp_en || got_d !== exp_d) begin
            n_fail++;
            $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
                     req, got_en, got_d, exp_en, exp_d);
        end
    endtask

    // Model of one clock edge, using only the inputs the bench drives
    task automatic model_step();
        logic          dv;
        logic [AW-1:0] da;
        logic [NB-1:0] db;
        int            op;
        logic [AW-1:0] oa;
        logic [1:0]    nb;
        logic          sel_now;
        logic          valid;
        logic [DW-1:0] data;
        sel_now = !cs0_n && cs1 && !cs2_n;
        dv = flow_mode ? s1v : s2v;
        da = flow_mode ? s1a : s2a;
        db = flow_mode ? s1b : s2b;
        epv = (m_st == 1);
        epd = refmem[m_ra];
        if (dv && da == m_ra) epd = merge_bytes(epd, din, db);
        if (dv) refmem[da] = merge_bytes(refmem[da], din, db);
        nb = m_cnt + 2'd1;
        oa = '0;
        if (doze) begin
            op = 0;
        end else if (burst_adv) begin
            op = (m_st == 1 || m_st == 2) ? m_st : 0;
            oa = {m_base[AW-1:2], beat_low(m_base[1:0], nb, order_xor)};
            if (op != 0) m_cnt = nb;
        end else if (sel_now) begin
            op = wr ? 2 : 1;
            oa = addr;
            m_base = addr;
            m_cnt = '0;
        end else begin
            op = 0;
        end
        s2v = s1v; s2a = s1a; s2b = s1b;
        s1v = (op == 2); s1a = oa; s1b = ben;
        m_st = op;
        m_ra = oa;
        valid = flow_mode ? (m_st == 1) : epv;
        data  = flow_mode ? refmem[m_ra] : epd;
        e_en = out_en && !doze && valid;
        e_d  = e_en ? data : '0;
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input logic s, input logic w, input logic a,
                       input logic [AW-1:0] ad, input logic [NB-1:0] b, input logic [DW-1:0] d);
        int pick;
        addr = ad; wr = w; ben = b; din = d; burst_adv = a;
        if (s) begin
            cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
        end else begin
            pick = $urandom % 3;
            cs0_n = (pick == 0); cs1 = (pick != 1); cs2_n = (pick == 2);
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(cur_req, rd_drive, rd_data, e_en, e_d);
    endtask

    function automatic logic [DW-1:0] rnd_word();
        return DW'($urandom);
    endfunction

    task automatic set_mode(input logic f);
        out_en = 1'b1; doze = 1'b0;
        repeat (3) cyc(1'b0, 1'b0, 1'b0, '0, '0, rnd_word());
        flow_mode = f;
    endtask

    initial begin
        #750000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: drive=%0b data=%h expected drive=x data=x", rd_drive, rd_data);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] d0, d1, d2, d3, old_w;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk("R1", rd_drive, rd_data, 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", rd_drive, rd_data, 1'b0, '0);

        // R4: fill every word in flow-through mode with late data
        cur_req = "R4";
        for (int i = 0; i < DEPTH; i++) cyc(1'b1, 1'b1, 1'b0, AW'(i), 2'b11, rnd_word());
        cyc(1'b0, 1'b0, 1'b0, '0, '0, rnd_word());
        cyc(1'b0, 1'b0, 1'b0, '0, '0, rnd_word());

        // R3: flow-through read drives right after its edge
        cur_req = "R3";
        cyc(1'b1, 1'b0, 1'b0, 6'd20, 2'b00, rnd_word());
        chk("R3", rd_drive, rd_data, 1'b1, refmem[20]);

        // R6: flow-through write then read of same word
        cur_req = "R6";
        d0 = rnd_word();
        cyc(1'b1, 1'b1, 1'b0, 6'd33, 2'b11, rnd_word());
        cyc(1'b1, 1'b0, 1'b0, 6'd33, 2'b00, d0);
        chk("R6", rd_drive, rd_data, 1'b1, d0);

        // R5: lower-byte-only write
        cur_req = "R5";
        old_w = refmem[7];
        d1 = rnd_word();
        cyc(1'b1, 1'b1, 1'b0, 6'd7, 2'b01, rnd_word());
        cyc(1'b0, 1'b0, 1'b0, '0, '0, d1);
        cyc(1'b1, 1'b0, 1'b0, 6'd7, 2'b00, rnd_word());
        chk("R5", rd_drive, rd_data, 1'b1, {old_w[17:9], d1[8:0]});

        // R2: write with one select wrong leaves the word unchanged
        cur_req = "R2";
        old_w = refmem[10];
        addr = 6'd10; wr = 1'b1; ben = 2'b11; burst_adv = 1'b0;
        cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b1; din = rnd_word();
        @(posedge clk); model_step(); @(negedge clk);
        chk("R2", rd_drive, rd_data, 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b0, '0, '0, rnd_word());
        cyc(1'b1, 1'b0, 1'b0, 6'd10, 2'b00, rnd_word());
        chk("R2", rd_drive, rd_data, 1'b1, old_w);

        // R11: advance after deselect is a no-op
        cur_req = "R11";
        cyc(1'b0, 1'b0, 1'b0, '0, '0, rnd_word());
        cyc(1'b0, 1'b0, 1'b1, 6'd3, 2'b11, rnd_word());
        chk("R11", rd_drive, rd_data, 1'b0, '0);

        // R7: linear burst from low bits 2: 6,7,4,5
        cur_req = "R7";
        order_xor = 1'b0;
        d0 = rnd_word(); d1 = rnd_word(); d2 = rnd_word(); d3 = rnd_word();
        cyc(1'b1, 1'b1, 1'b0, 6'd6, 2'b11, rnd_word());
        cyc(1'b0, 1'b0, 1'b1, '0, 2'b11, d0);
        cyc(1'b0, 1'b0, 1'b1, '0, 2'b11, d1);
        cyc(1'b0, 1'b0, 1'b1, '0, 2'b11, d2);
        cyc(1'b0, 1'b0, 1'b0, '0, '0, d3);
        cyc(1'b1, 1'b0, 1'b0, 6'd4, 2'b00, rnd_word());
        chk("R7", rd_drive, rd_data, 1'b1, d2);
        cyc(1'b1, 1'b0, 1'b0, 6'd5, 2'b00, rnd_word());
        chk("R7", rd_drive, rd_data, 1'b1, d3);

        // R8: XOR burst from low bits 1: 13,12,15,14
        cur_req = "R8";
        order_xor = 1'b1;
        d0 = rnd_word(); d1 = rnd_word(); d2 = rnd_word(); d3 = rnd_word();
        cyc(1'b1, 1'b1, 1'b0, 6'd13, 2'b11, rnd_word());
        cyc(1'b0, 1'b0, 1'b1, '0, 2'b11, d0);
        cyc(1'b0, 1'b0, 1'b1, '0, 2'b11, d1);
        cyc(1'b0, 1'b0, 1'b1, '0, 2'b11, d2);
        cyc(1'b0, 1'b0, 1'b0, '0, '0, d3);
        cyc(1'b1, 1'b0, 1'b0, 6'd15, 2'b00, rnd_word());
        chk("R8", rd_drive, rd_data, 1'b1, d2);
        cyc(1'b1, 1'b0, 1'b0, 6'd12, 2'b00, rnd_word());
        chk("R8", rd_drive, rd_data, 1'b1, d1);

        // R9: output enable cuts the drive without a clock
        cur_req = "R9";
        cyc(1'b1, 1'b0, 1'b0, 6'd3, 2'b00, rnd_word());
        out_en = 1'b0; #1;
        chk("R9", rd_drive, rd_data, 1'b0, '0);
        out_en = 1'b1; #1;
        chk("R9", rd_drive, rd_data, 1'b1, refmem[3]);

        // R10: doze drops commands and keeps contents
        cur_req = "R10";
        old_w = refmem[9];
        doze = 1'b1; #1;
        chk("R10", rd_drive, rd_data, 1'b0, '0);
        cyc(1'b1, 1'b1, 1'b0, 6'd9, 2'b11, rnd_word());
        cyc(1'b0, 1'b0, 1'b0, '0, '0, rnd_word());
        cyc(1'b0, 1'b0, 1'b0, '0, '0, rnd_word());
        doze = 1'b0;
        cyc(1'b1, 1'b0, 1'b0, 6'd9, 2'b00, rnd_word());
        chk("R10", rd_drive, rd_data, 1'b1, old_w);

        // Pipelined mode
        order_xor = 1'b0;
        set_mode(1'b0);
        cur_req = "R3";
        cyc(1'b1, 1'b0, 1'b0, 6'd22, 2'b00, rnd_word());
        chk("R3", rd_drive, rd_data, 1'b0, '0);
        cyc(1'b0, 1'b0, 1'b0, '0, '0, rnd_word());
        chk("R3", rd_drive, rd_data, 1'b1, refmem[22]);

        // R6: write, read same word, write; read sees forwarded data
        cur_req = "R6";
        d0 = rnd_word();
        cyc(1'b1, 1'b1, 1'b0, 6'd5, 2'b11, rnd_word());
        cyc(1'b1, 1'b0, 1'b0, 6'd5, 2'b00, rnd_word());
        cyc(1'b1, 1'b1, 1'b0, 6'd6, 2'b11, d0);
        chk("R6", rd_drive, rd_data, 1'b1, d0);
        cyc(1'b1, 1'b0, 1'b0, 6'd5, 2'b00, rnd_word());
        cyc(1'b0, 1'b0, 1'b0, '0, '0, rnd_word());
        chk("R6", rd_drive, rd_data, 1'b1, d0);
        cyc(1'b0, 1'b0, 1'b0, '0, '0, rnd_word());

        // R6: seeded random traffic in both modes, hit-heavy addresses
        for (int m = 0; m < 2; m++) begin
            set_mode(m == 0 ? 1'b0 : 1'b1);
            order_xor = (m == 1);
            cur_req = "R6";
            for (int i = 0; i < 400; i++) begin
                out_en = ($urandom % 10) != 0;
                doze   = ($urandom % 30) == 0;
                cyc(($urandom % 5) != 0, $urandom % 2, ($urandom % 10) < 3,
                    (($urandom % 4) == 0) ? AW'($urandom) : AW'($urandom % 8),
                    NB'($urandom), rnd_word());
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule